// File: doc/BRIEF.md
# Two-Bank Interleaved DRAM Access Controller

This controller sits between a 32-bit processor bus and two DRAM banks that share one multiplexed row/column address bus. For each bus request that falls inside its decoded address window, it strobes the row address with a bank's row strobe, moves the multiplexer to the column address, and then asserts the column strobe. It raises a one-cycle ready pulse to the processor in the same cycle. All analog delays of a discrete design are replaced by whole clock cycles.

In two-bank mode, byte-address bit 2 picks the bank. Each bank has its own precharge timer, so a request to the other bank can start at once while the first bank recovers. A static strap selects single-bank mode. In that mode bit 2 becomes the lowest column bit, both row-strobe pins carry the same strobe for extra drive, and every back-to-back access pays the precharge penalty.

The row strobe is released in the cycle after the column-strobe cycle, before the processor starts its next bus cycle. This gives the bank's precharge an early start. The processor holds off a new request until ready has pulsed, and issues it no earlier than the cycle after ready.

Top module: `dram_ilv_ctrl`

## Requirements
- R1: During and just after reset, both row strobes, the column strobe and the write strobe are high (inactive), ready is low, and the multiplexer select is 0 (row).
- R2: A request accepted in cycle k with its bank already precharged proceeds as follows. In cycle k+1 the row strobe goes low with `row_col_sel_o`=0. In cycle k+2 the select is 1 (column). In cycle k+3 the column strobe is low and `rdy_o` is 1 for exactly that cycle. This gives two wait states.
- R3: In two-bank mode, address bit 2 = 0 drives `ras_n_o[0]` low and bit 2 = 1 drives `ras_n_o[1]` low. The two are never low together.
- R4: In two-bank mode, `ma_o` carries address bits [3+MA_W-1:3] in the column phase and bits [3+2*MA_W-1:3+MA_W] in the row phase.
- R5: In single-bank mode, `ras_n_o[1]` equals `ras_n_o[0]`. The column is address bits [2+MA_W-1:2] and the row is bits [2+2*MA_W-1:2+MA_W].
- R6: Both row strobes and the column strobe are high in the cycle after the ready cycle.
- R7: After a bank's row strobe rises, it stays high for at least PRE_CYC cycles before it falls again. A request that arrives earlier is stalled with all strobes high, and ready is delayed accordingly.
- R8: Back-to-back requests, each issued the cycle after the previous ready, behave as follows. In two-bank mode, alternating banks get ready three cycles after the request. With the default PRE_CYC=2, single-bank requests get ready four cycles after the request (three wait states).
- R9: A request whose address bits [31:3+2*MA_W] differ from the same bits of BASE is ignored. All strobes stay high and ready stays low.
- R10: `we_n_o` is low from the row cycle through the ready cycle of a write access, and high for reads and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| single_bank_i | input | 1 | Strap: 1 = single-bank mode, 0 = two-bank interleaved |
| req_i | input | 1 | Bus request, one-cycle pulse while controller idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| ras_n_o | output | 2 | Row strobes, active low, index = bank |
| cas_n_o | output | 1 | Column strobe, active low |
| row_col_sel_o | output | 1 | Address multiplexer select, 1 = column |
| ma_o | output | MA_W | Multiplexed row/column address |
| we_n_o | output | 1 | Write strobe, active low |
| rdy_o | output | 1 | Ready to processor, one cycle per access |

## Verification
Faults in this block show up as timing faults. A precharge timer that is stuck or loaded for the wrong bank shows up on the first back-to-back access to that bank: the row strobe falls a cycle early or late, and ready moves with it. A wrong latched bank or mode shows up within one cycle of the row strobe, because the wrong strobe pin falls or the wrong address slice appears on `ma_o`. The bench predicts every output in every cycle from a timing model of request times and per-bank release times. Any such fault is therefore caught in the cycle it first appears.

// File: rtl/dram_ilv_pkg.sv
package dram_ilv_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_PRE,
    SEQ_RAS,
    SEQ_COL,
    SEQ_CAS
  } seq_e;
endpackage

// File: rtl/dram_addr_map.sv
module dram_addr_map #(
  parameter int MA_W = 10
) (
  input  logic [31:0]     addr_i,
  input  logic            single_i,
  output logic            bank_o,
  output logic [MA_W-1:0] row_o,
  output logic [MA_W-1:0] col_o
);
  localparam int OFS_TWO = 3;
  localparam int OFS_ONE = 2;

  always_comb begin
    if (single_i) begin
      // bit 2 becomes the lowest column bit
      bank_o = 1'b0;
      col_o  = addr_i[OFS_ONE +: MA_W];
      row_o  = addr_i[OFS_ONE+MA_W +: MA_W];
    end else begin
      bank_o = addr_i[2];
      col_o  = addr_i[OFS_TWO +: MA_W];
      row_o  = addr_i[OFS_TWO+MA_W +: MA_W];
    end
  end
endmodule

// File: rtl/dram_pre_timer.sv
module dram_pre_timer #(
  parameter int NB      = 2,
  parameter int PRE_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] load_i,
  output logic [NB-1:0] soon_o,
  output logic [NB-1:0] zero_o
);
  localparam int CW = $clog2(PRE_CYC + 1);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (load_i[g])    cnt_q <= CW'(PRE_CYC);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // soon: counter reaches zero by next cycle
    assign soon_o[g] = (cnt_q <= CW'(1));
    assign zero_o[g] = (cnt_q == '0);

    assert_load_expired_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i[g] |-> cnt_q == '0);
    assert_cnt_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CW'(PRE_CYC));
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ilv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pre_ok_i,
  output seq_e state_o,
  output logic ras_act_o,
  output logic mux_col_o,
  output logic cas_o,
  output logic rdy_o
);
  seq_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (start_i) state_d = pre_ok_i ? SEQ_RAS : SEQ_PRE;
      SEQ_PRE:  if (pre_ok_i) state_d = SEQ_RAS;
      SEQ_RAS:  state_d = SEQ_COL;
      SEQ_COL:  state_d = SEQ_CAS;
      SEQ_CAS:  state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign ras_act_o = (state_q == SEQ_RAS) || (state_q == SEQ_COL) || (state_q == SEQ_CAS);
  assign mux_col_o = (state_q == SEQ_COL) || (state_q == SEQ_CAS);
  assign cas_o     = (state_q == SEQ_CAS);
  assign rdy_o     = (state_q == SEQ_CAS);

  assert_mux_after_ras_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mux_col_o) |-> $past(ras_act_o) && ras_act_o);
  assert_cas_after_mux_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_o) |-> $past(mux_col_o));
  assert_rdy_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);
  assert_ras_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_o |=> !ras_act_o && !cas_o);
endmodule

// File: rtl/dram_ilv_ctrl.sv
module dram_ilv_ctrl
  import dram_ilv_pkg::*;
#(
  parameter int          MA_W    = 10,
  parameter int          PRE_CYC = 2,
  parameter logic [31:0] BASE    = 32'h4000_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            single_bank_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [31:0]     addr_i,
  output logic [1:0]      ras_n_o,
  output logic            cas_n_o,
  output logic            row_col_sel_o,
  output logic [MA_W-1:0] ma_o,
  output logic            we_n_o,
  output logic            rdy_o
);
  localparam int NB      = 2;
  localparam int DEC_LSB = 3 + 2 * MA_W;

  logic            bank_d, bank_q;
  logic [MA_W-1:0] row_d, col_d, row_q, col_q;
  logic            we_q;
  logic            hit, accept, pre_ok;
  logic [NB-1:0]   soon, zero, load;
  logic            ras_act, mux_col, cas_act, rdy;
  seq_e            state;

  assign hit    = (addr_i[31:DEC_LSB] == BASE[31:DEC_LSB]);
  assign accept = (state == SEQ_IDLE) && req_i && hit;

  dram_addr_map #(.MA_W(MA_W)) u_map (
    .addr_i   (addr_i),
    .single_i (single_bank_i),
    .bank_o   (bank_d),
    .row_o    (row_d),
    .col_o    (col_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      we_q   <= 1'b0;
    end else if (accept) begin
      bank_q <= bank_d;
      row_q  <= row_d;
      col_q  <= col_d;
      we_q   <= we_i;
    end
  end

  // idle: incoming bank; stalled: latched bank
  assign pre_ok = (state == SEQ_IDLE) ? soon[bank_d] : soon[bank_q];
  assign load   = {cas_act && bank_q, cas_act && !bank_q};

  dram_pre_timer #(.NB(NB), .PRE_CYC(PRE_CYC)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .soon_o (soon),
    .zero_o (zero)
  );

  dram_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (req_i && hit),
    .pre_ok_i  (pre_ok),
    .state_o   (state),
    .ras_act_o (ras_act),
    .mux_col_o (mux_col),
    .cas_o     (cas_act),
    .rdy_o     (rdy)
  );

  assign ras_n_o[0]    = !(ras_act && (single_bank_i || !bank_q));
  assign ras_n_o[1]    = !(ras_act && (single_bank_i ||  bank_q));
  assign cas_n_o       = !cas_act;
  assign row_col_sel_o = mux_col;
  assign ma_o          = mux_col ? col_q : row_q;
  assign we_n_o        = !(ras_act && we_q);
  assign rdy_o         = rdy;

  assert_cs_miss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == SEQ_IDLE) && req_i && !hit |=> ras_n_o == 2'b11 && cas_n_o && !rdy_o);
  assert_one_bank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !single_bank_i |-> $countones(~ras_n_o) <= 1);
  assert_rdy_cas_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> !cas_n_o && row_col_sel_o);

  for (genvar g = 0; g < NB; g++) begin : g_chk
    assert_ras_after_pre_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ras_n_o[g]) && (g == 0 || !single_bank_i) |-> zero[g]);
  end
endmodule

// File: tb/dram_ilv_ctrl_tb.sv
`timescale 1ns/1ps
module dram_ilv_ctrl_tb;
  localparam int          MA_W = 10;
  localparam int          PRE  = 2;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            single_bank_i = 1'b0;
  logic            req_i = 1'b0;
  logic            we_i = 1'b0;
  logic [31:0]     addr_i = '0;
  logic [1:0]      ras_n_o;
  logic            cas_n_o, row_col_sel_o, we_n_o, rdy_o;
  logic [MA_W-1:0] ma_o;

  always #2.5 clk = ~clk;

  dram_ilv_ctrl #(.MA_W(MA_W), .PRE_CYC(PRE), .BASE(BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .single_bank_i(single_bank_i), .req_i(req_i),
    .we_i(we_i), .addr_i(addr_i), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .row_col_sel_o(row_col_sel_o), .ma_o(ma_o), .we_n_o(we_n_o), .rdy_o(rdy_o)
  );

  int    n_tests = 0, n_fail = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R1";
  // timing model of the one outstanding access
  bit              have = 0;
  int              st;
  bit              m_bank, m_sb, m_we;
  logic [MA_W-1:0] m_row, m_col;
  int              rel [2] = '{-1000, -1000};

  task automatic check_cycle(int c);
    logic [1:0]      e_ras = 2'b11;
    logic            e_cas = 1, e_mux = 0, e_rdy = 0, e_we = 1, chk_ma = 0;
    logic [MA_W-1:0] e_ma = '0;
    bit              bad;
    if (have && c >= st && c <= st + 2) begin
      int ph = c - st;
      e_ras  = m_sb ? 2'b00 : (m_bank ? 2'b01 : 2'b10);
      e_mux  = (ph > 0);
      e_cas  = (ph != 2);
      e_rdy  = (ph == 2);
      e_we   = !m_we;
      e_ma   = (ph == 0) ? m_row : m_col;
      chk_ma = 1;
    end
    bad = (ras_n_o !== e_ras) || (cas_n_o !== e_cas) || (row_col_sel_o !== e_mux) ||
          (rdy_o !== e_rdy) || (we_n_o !== e_we) || (chk_ma && ma_o !== e_ma);
    n_tests++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s cyc %0d: ras_n=%b/%b cas_n=%b/%b sel=%b/%b rdy=%b/%b we_n=%b/%b ma=%h/%h (act/exp)",
               cur_req, c, ras_n_o, e_ras, cas_n_o, e_cas, row_col_sel_o, e_mux,
               rdy_o, e_rdy, we_n_o, e_we, ma_o, e_ma);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    check_cycle(cyc);
  endtask

  // request at current cycle; hit = address inside window
  task automatic issue(logic [31:0] a, logic w, bit hit);
    addr_i = a; we_i = w; req_i = 1'b1;
    if (hit) begin
      int ofs = single_bank_i ? 2 : 3;
      m_sb   = single_bank_i;
      m_bank = single_bank_i ? 1'b0 : a[2];
      m_we   = w;
      m_col  = MA_W'(a >> ofs);
      m_row  = MA_W'(a >> (ofs + MA_W));
      st     = (cyc + 1 > rel[m_bank] + PRE) ? cyc + 1 : rel[m_bank] + PRE;
      rel[m_bank] = st + 3;
      have   = 1;
    end
    tick();
    req_i = 1'b0;
    if (hit) while (cyc < st + 3) tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R2, R3, R4: two-bank read bank 0, write bank 1
    cur_req = "R2_R3_R4";
    issue(BASE | 32'h0012_3450, 1'b0, 1);
    idle(4);
    issue(BASE | 32'h0045_6784, 1'b1, 1);
    idle(4);

    // R8: alternating banks back-to-back, no stall
    cur_req = "R8";
    issue(BASE | 32'h0000_1000, 1'b0, 1);
    issue(BASE | 32'h0000_2004, 1'b0, 1);
    issue(BASE | 32'h0000_3008, 1'b1, 1);
    issue(BASE | 32'h0000_400C, 1'b0, 1);

    // R7: same bank back-to-back stalls; one idle cycle removes it
    cur_req = "R7";
    issue(BASE | 32'h0010_0000, 1'b0, 1);
    issue(BASE | 32'h0020_0008, 1'b0, 1);
    tick();
    issue(BASE | 32'h0030_0010, 1'b1, 1);
    issue(BASE | 32'h0031_0014, 1'b0, 1);
    issue(BASE | 32'h0032_001C, 1'b0, 1);

    // R9: addresses outside the window
    cur_req = "R9";
    issue(32'h0000_1234, 1'b1, 0);
    idle(3);
    issue(32'hC040_0004, 1'b0, 0);
    idle(3);

    // R5, R6, R8: single-bank mode, back-to-back with bit 2 as column bit
    single_bank_i = 1'b1;
    idle(4);
    cur_req = "R5_R6_R8";
    issue(BASE | 32'h0012_3454, 1'b0, 1);
    issue(BASE | 32'h0012_3450, 1'b1, 1);
    issue(BASE | 32'h007F_FFFC, 1'b0, 1);
    idle(3);

    // R10: writes in both modes
    cur_req = "R10";
    issue(BASE | 32'h0001_0004, 1'b1, 1);
    single_bank_i = 1'b0;
    idle(4);
    issue(BASE | 32'h0001_0004, 1'b1, 1);
    issue(BASE | 32'h0001_0000, 1'b1, 1);
    idle(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500_000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule